// File: doc/BRIEF.md
# UART Baud Tick Generator with Prescale Bypass

This block turns a fixed reference clock into the 16x oversampling tick that a UART transmitter and receiver use. Software programs a 16-bit divisor as two byte registers. The low 15 bits set the count length. The top bit can select a faster clock path, so the block reaches four times the normal top rate without a second reference clock.

In the normal path, a fixed divide-by-4 prescaler sits in front of the rate counter. With the 7.3728 MHz reference, a divisor of 1 then gives 115200 baud. When the high-speed enable input is asserted and divisor bit 15 is set, the prescaler is bypassed and the reference drives the rate counter directly. In that mode divisors 0x8001, 0x8002, 0x8003 and 0x8004 give 460800, 230400, 153600 and 115200 baud.

Both divisor bytes read back unchanged. A write to either byte restarts the count at once, so a new rate takes effect without waiting for the old count to finish.

Top module: `baud_gen_top`

## Requirements
- R1: After reset both divisor bytes read back as 0 and `tick_o` stays low until a divisor with non-zero low 15 bits is written.
- R2: A write with `wr_sel_i`=0 sets divisor bits 7:0 and a write with `wr_sel_i`=1 sets bits 15:8. `rd_data_o` returns the low byte for `rd_sel_i`=0 and the high byte for `rd_sel_i`=1, exactly as written. A write to one byte leaves the other byte unchanged.
- R3: With the prescaler active, `tick_o` pulses once every 4*D reference cycles, where D is divisor bits 14:0.
- R4: With `hs_en_i`=1 and divisor bit 15 = 1, `tick_o` pulses once every D reference cycles. 0x8001 gives a tick on every cycle.
- R5: With `hs_en_i`=0, divisor bit 15 has no effect and the period is 4*D.
- R6: Only bits 14:0 divide, so 0xFFFF in high-speed mode gives a period of 32767 cycles.
- R7: A divisor whose bits 14:0 are 0 (for example 0x0000 or 0x8000) produces no tick.
- R8: A divisor write on clock edge k restarts the count. The first tick at the new rate is high after edge k+1+P, where P is the new period.
- R9: When P > 1, each tick is high for exactly one reference cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Divisor byte write strobe |
| wr_sel_i | input | 1 | Write byte select: 0 = low byte, 1 = high byte |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read byte select: 0 = low byte, 1 = high byte |
| rd_data_o | output | 8 | Selected divisor byte |
| hs_en_i | input | 1 | High-speed enable; lets divisor bit 15 bypass the prescaler |
| tick_o | output | 1 | 16x oversampling tick, one cycle wide |

## Verification
The bench builds the block with its default parameters: a prescale of 4, a 16-bit divisor and 8-bit bytes. With these values the bypass path can be checked over the whole 15-bit range, up to the 32767-cycle period, within the cycle budget. The prescaled path is checked with random small divisors, with both settings of bit 15 and of the high-speed enable. The first-tick delay after each write is checked as well as the steady interval between ticks.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } byte_sel_e;

  localparam int unsigned DEF_PRESCALE = 4;
  localparam int unsigned DEF_DATA_W   = 8;
  localparam int unsigned DEF_BYTES    = 2;
endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_BYTES = 2,
  localparam int unsigned SEL_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int unsigned DIV_W    = DATA_W * NUM_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              load_o
);
  logic [DATA_W-1:0] byte_q [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        byte_q[g] <= '0;
      else if (wr_en_i && (wr_sel_i == SEL_W'(g)))        byte_q[g] <= wr_data_i;
    end
    assign div_o[g*DATA_W +: DATA_W] = byte_q[g];

    // R2: the selected byte captures the written data, other bytes hold
    p_byte_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_sel_i == SEL_W'(g)) |=> byte_q[g] == $past(wr_data_i));
    p_byte_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_sel_i == SEL_W'(g)) |=> $stable(byte_q[g]));
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_BYTES; i++)
      if (rd_sel_i == SEL_W'(i)) rd_data_o = byte_q[i];
  end

  // restart strobe, seen by counters one cycle after the latch updates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_o <= 1'b0;
    else         load_o <= wr_en_i;
  end
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int unsigned PRESCALE = 4,
  localparam int unsigned PS_W    = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic bypass_i,
  output logic pre_en_o
);
  if (PRESCALE == 1) begin : g_none
    assign pre_en_o = 1'b1;
  end else begin : g_div
    logic [PS_W-1:0] pcnt_q;
    logic            wrap;
    assign wrap = (pcnt_q == PS_W'(PRESCALE - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pcnt_q <= '0;
      else if (load_i) pcnt_q <= '0;
      else if (wrap)   pcnt_q <= '0;
      else             pcnt_q <= pcnt_q + PS_W'(1);
    end

    assign pre_en_o = bypass_i | wrap;

    // R3: the prescaled enable never fires on two adjacent cycles
    p_pre_spacing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!bypass_i && pre_en_o) |=> (bypass_i || !pre_en_o));
  end
endmodule

// File: rtl/baud_rate_counter.sv
module baud_rate_counter #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             pre_en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;
  logic             stopped;

  assign stopped = (limit_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (load_i || stopped) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (pre_en_i) begin
      if (cnt_q >= limit_i - CNT_W'(1)) begin
        cnt_q  <= '0;
        tick_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + CNT_W'(1);
        tick_q <= 1'b0;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  // R7: a zero limit silences the tick
  p_zero_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped |=> !tick_q);
  // R8: a restart always begins with the tick low and the count cleared
  p_load_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!tick_q && cnt_q == '0));
  // R6: count stays inside the programmed 15-bit range
  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !stopped) |-> cnt_q < limit_i);
  // R9: no tick without a counter enable
  p_tick_needs_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pre_en_i) |=> !tick_q);
endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top #(
  parameter int unsigned PRESCALE  = baud_pkg::DEF_PRESCALE,
  parameter int unsigned DATA_W    = baud_pkg::DEF_DATA_W,
  parameter int unsigned NUM_BYTES = baud_pkg::DEF_BYTES,
  localparam int unsigned DIV_W    = DATA_W * NUM_BYTES,
  localparam int unsigned CNT_W    = DIV_W - 1,
  localparam int unsigned SEL_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              hs_en_i,
  output logic              tick_o
);
  logic [DIV_W-1:0] div;
  logic             load;
  logic             bypass;
  logic             pre_en;

  baud_div_latch #(.DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES)) u_latch (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .rd_sel_i, .rd_data_o,
    .div_o(div), .load_o(load)
  );

  // top divisor bit selects the fast path only in high-speed mode
  assign bypass = hs_en_i & div[DIV_W-1];

  baud_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i, .rst_ni, .load_i(load), .bypass_i(bypass), .pre_en_o(pre_en)
  );

  baud_rate_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .pre_en_i(pre_en),
    .limit_i(div[CNT_W-1:0]), .tick_o
  );

  // R5: with high-speed mode off the fast path is never taken
  p_hs_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs_en_i |-> !bypass);
endmodule

// File: tb/baud_gen_top_bench.sv
module baud_gen_top_bench;
  import baud_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       hs_en = 1'b0;
  logic       tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_gen_top u_baud_gen_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .hs_en_i(hs_en), .tick_o(tick)
  );

  function automatic int exp_period(input logic [15:0] d, input logic hs);
    int n = int'(d[14:0]);
    if (hs && d[15]) return n;
    return 4 * n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_byte(input byte_sel_e s, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_div(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = SEL_LO; wr_data = d[7:0];
    @(negedge clk);
    wr_sel = SEL_HI; wr_data = d[15:8];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_byte(input byte_sel_e s, output logic [7:0] v);
    rd_sel = s;
    #1 v = rd_data;
  endtask

  // called right after a write; checks first-tick delay, interval and width
  task automatic measure(input string req, input logic [15:0] d);
    int p = exp_period(d, hs_en);
    int c = 1;
    int first = -1;
    int second = -1;
    logic width_bad = 1'b0;
    while (second < 0 && c < p * 2 + 8) begin
      @(negedge clk); c++;
      if (tick) begin
        if (first < 0) begin
          first = c;
          if (p > 1) begin
            @(negedge clk); c++;
            if (tick) width_bad = 1'b1;
          end
        end else second = c;
      end
    end
    check({req, " first tick"}, first, p + 2);
    check({req, " interval"}, second - first, p);
    if (p > 1) check("R9 tick width", int'(width_bad), 0);
  endtask

  task automatic no_tick(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    check(req, seen, 0);
  endtask

  initial begin
    #(20 * 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_byte(SEL_LO, v); check("R1 low byte", int'(v), 0);
    rd_byte(SEL_HI, v); check("R1 high byte", int'(v), 0);
    no_tick("R1 no tick after reset", 40);

    // R2 byte readback, independent bytes
    wr_byte(SEL_LO, 8'hA5);
    wr_byte(SEL_HI, 8'h3C);
    rd_byte(SEL_LO, v); check("R2 low byte", int'(v), 8'hA5);
    rd_byte(SEL_HI, v); check("R2 high byte", int'(v), 8'h3C);
    wr_byte(SEL_LO, 8'h0F);
    rd_byte(SEL_HI, v); check("R2 high kept", int'(v), 8'h3C);
    rd_byte(SEL_LO, v); check("R2 low new", int'(v), 8'h0F);

    // R3 prescaled, R8 restart
    hs_en = 1'b0;
    wr_div(16'h0001); measure("R3 div1", 16'h0001);
    wr_div(16'h0005); measure("R8 restart div5", 16'h0005);

    // R4 bypass rates
    hs_en = 1'b1;
    wr_div(16'h8001); measure("R4 8001", 16'h8001);
    wr_div(16'h8002); measure("R4 8002", 16'h8002);
    wr_div(16'h8003); measure("R4 8003", 16'h8003);
    wr_div(16'h8004); measure("R4 8004", 16'h8004);

    // R5 bit 15 ignored when high-speed is off
    hs_en = 1'b0;
    wr_div(16'h8003); measure("R5 8003 hs off", 16'h8003);
    hs_en = 1'b1;
    wr_div(16'h0003); measure("R3 hs on bit15 clear", 16'h0003);

    // R7 zero low bits
    wr_div(16'h8000); no_tick("R7 8000", 60);
    wr_div(16'h0000); no_tick("R7 0000", 60);

    // R8 rewrite mid-count: long period, then fast rate right away
    hs_en = 1'b0;
    wr_div(16'h0100);
    repeat (37) @(negedge clk);
    wr_div(16'h0002); measure("R8 midcount", 16'h0002);

    // random mix
    for (int i = 0; i < 12; i++) begin
      logic [15:0] d;
      d = {1'($urandom()), 15'(1 + ($urandom() % 20))};
      hs_en = 1'($urandom());
      wr_div(d);
      measure(hs_en && d[15] ? "R4 random" : "R3 random", d);
    end

    // R6 top of range in bypass
    hs_en = 1'b1;
    wr_div(16'hFFFF); measure("R6 FFFF", 16'hFFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule